// File: doc/BRIEF.md
# Real-Time Clock Interrupt Source and Flag Unit

This unit is the interrupt control and status logic of a PC-style real-time clock. It counts a 32.768 kHz reference tick and produces a periodic event at a rate picked by a 4-bit selector. It latches three event sources, each in its own flag: periodic, alarm-match and update-ended. It drives one level interrupt line. The alarm-match and update-ended events arrive from neighbouring logic as single-cycle pulses. The periodic event is made inside the unit.

Software reaches the unit through a byte-wide register port with three registers:

- a control register that holds the three per-source enable bits;
- a rate register that holds the selector;
- a flags register.

A flag latches its event even when that source's enable is off. The summary bit and the interrupt line react only to a flag whose enable is set. Reading the flags register returns its value and clears it in the same access. Software uses that read to flush stale events before it enables new sources. An event that coincides with the clearing read is kept for the next read.

Top module: `rtci_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the rate register (address 1) reads 0x06, the flags register (address 2) reads 0x00 and `irq_o` is low.
- R2: A rate value of 0 produces no periodic event, so the periodic flag never sets.
- R3: The periodic event repeats every 2^(n-1) reference ticks for rate values n = 3..15. It repeats every 128 ticks for n = 1 and every 256 ticks for n = 2. The reset value 6 therefore gives 1024 Hz from a 32.768 kHz reference.
- R4: In the flags register, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Bits 3..0 read as zero. Each flag sets on its event whether or not its enable is set.
- R5: Control bits 6, 5 and 4 enable the periodic, alarm and update sources. Flags bit 7 and `irq_o` are high exactly when some flag is set together with its matching enable.
- R6: A read of address 2 returns the current flags and clears all of them at the end of that access.
- R7: An event that arrives in the same cycle as a clearing read of address 2 is not in the returned value. It stays set and is returned by the next read.
- R8: `irq_o` is a high level. Once high, it stays high until the flags register is read or the matching enables are cleared. Re-enabling a source whose flag is still latched raises it again.
- R9: Writes to address 2 are ignored. The control register keeps only bits 6..4 and the rate register keeps only bits 3..0; the other bits read as zero. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| alarm_evt | input | 1 | One-cycle alarm-match event |
| update_evt | input | 1 | One-cycle update-ended event |
| rd_en | input | 1 | Register read strobe; a read of address 2 clears the flags |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 rate, 2 flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; combinational from the addressed register |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The divider is swept over every rate value 1..15, with the reference tick held high on every cycle and the flags polled every cycle. The measured spacing between two periodic flags then separates each selector value from its neighbours and from the special codes 1 and 2. Rate 0 is held for longer than the slowest special period to show that it makes no events. The alarm and update pulses are fed with their enables both on and off, which separates the latched flag from the summary bit. A pulse placed in the very cycle of a clearing read shows that coincident events survive, and timed enable writes show that the interrupt level is held and released.

// File: rtl/rtci_pkg.sv
package rtci_pkg;
   localparam int REG_AW     = 2;
   localparam logic [REG_AW-1:0] ADDR_CTRL  = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_RATE  = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_FLAGS = 2'd2;

   localparam int NSRC      = 3;   // periodic, alarm, update
   localparam int BIT_SUM   = 7;
   localparam int BIT_SRC_L = 4;   // lowest source bit; sources occupy 6..4
   localparam logic [7:0] CTRL_KEEP = 8'h70;
   localparam logic [7:0] RATE_KEEP = 8'h0F;
   localparam logic [7:0] RATE_INIT = 8'h06;

   // log2 of the periodic interval in reference ticks
   function automatic int rate_shift(input logic [3:0] sel);
      if (sel == 4'd1)      return 7;
      else if (sel == 4'd2) return 8;
      else                  return int'(sel) - 1;
   endfunction
endpackage

// File: rtl/rtci_rate_div.sv
module rtci_rate_div #(
   parameter int DIV_W = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [3:0] sel,
   output logic       pevt
);
   import rtci_pkg::*;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      mask = '0;
      for (int i = 0; i < DIV_W; i++)
         if (i < rate_shift(sel)) mask[i] = 1'b1;
   end

   assign pevt = tick && (sel != 4'd0) && ((cnt_q & mask) == mask);

   // R2
   rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 4'd0) |-> !pevt);
endmodule

// File: rtl/rtci_flag_bank.sv
module rtci_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr,
   output logic [N-1:0] flags
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f_q <= 1'b0;
         else        f_q <= (f_q && !clr) || evt[g];
      end
      assign flags[g] = f_q;

      // R7
      evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[g] |=> f_q);
      // R6
      clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !evt[g]) |=> !f_q);
      // R4
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (f_q && !clr) |=> f_q);
   end
endmodule

// File: rtl/rtci_top.sv
module rtci_top #(
   parameter int DIV_W = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_tick,
   input  logic       alarm_evt,
   input  logic       update_evt,
   input  logic       rd_en,
   input  logic       wr_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq_o
);
   import rtci_pkg::*;

   if (DIV_W < 14) begin : g_bad_width
      $error("rtci_top: DIV_W must be at least 14");
   end

   logic [7:0]      ctrl_q, rate_q;
   logic [NSRC-1:0] evt, flags, enables;
   logic            pevt, flag_rd, sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 8'h00;
         rate_q <= RATE_INIT;
      end else if (wr_en) begin
         if (addr == ADDR_CTRL) ctrl_q <= wdata & CTRL_KEEP;
         if (addr == ADDR_RATE) rate_q <= wdata & RATE_KEEP;
      end
   end

   rtci_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick), .sel(rate_q[3:0]), .pevt(pevt));

   assign evt     = {pevt, alarm_evt, update_evt};
   assign flag_rd = rd_en && (addr == ADDR_FLAGS);

   rtci_flag_bank #(.N(NSRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr(flag_rd), .flags(flags));

   assign enables = ctrl_q[BIT_SRC_L +: NSRC];
   assign sum     = |(flags & enables);
   assign irq_o   = sum;

   always_comb begin
      unique case (addr)
         ADDR_CTRL:  rdata = ctrl_q;
         ADDR_RATE:  rdata = rate_q;
         ADDR_FLAGS: rdata = {sum, flags, 4'b0000};
         default:    rdata = 8'h00;
      endcase
   end

   // R5
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ctrl_q[6:4] != 3'b000));
   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !flag_rd && !(wr_en && addr == ADDR_CTRL)) |=> irq_o);
   // R9
   rate_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_q[7:4] == 4'h0);
endmodule

// File: tb/tb_rtci_top.sv
`timescale 1ns/1ps
module tb_rtci_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0, alarm_evt = 1'b0, update_evt = 1'b0;
   logic       rd_en = 1'b0, wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_o;
   int checks = 0, errs = 0;

   always #2 clk = ~clk;

   rtci_top dut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .alarm_evt(alarm_evt), .update_evt(update_evt), .rd_en(rd_en),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
      rd_en = 1'b1; addr = a;
      #1 v = rdata;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input int which);
      if (which == 0) alarm_evt = 1'b1; else update_evt = 1'b1;
      @(posedge clk); @(negedge clk);
      alarm_evt = 1'b0; update_evt = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      do_rd(2'd0, v); check("R1 ctrl", v, 8'h00);
      do_rd(2'd1, v); check("R1 rate", v, 8'h06);
      do_rd(2'd2, v); check("R1 flags", v, 8'h00);
      check("R1 irq", irq_o, 0);

      // R9 register masking and read-only flags
      do_wr(2'd1, 8'hF3); do_rd(2'd1, v); check("R9 rate mask", v, 8'h03);
      do_wr(2'd0, 8'hFF); do_rd(2'd0, v); check("R9 ctrl mask", v, 8'h70);
      do_wr(2'd0, 8'h00);
      do_wr(2'd2, 8'hFF); do_rd(2'd2, v); check("R9 flags write ignored", v, 8'h00);
      do_rd(2'd3, v); check("R9 addr3", v, 8'h00);

      // R2 rate 0: no periodic flag with ticks every cycle
      do_wr(2'd1, 8'h00);
      ref_tick = 1'b1;
      do_rd(2'd2, v);
      repeat (600) @(negedge clk);
      do_rd(2'd2, v); check("R2 no periodic flag", v, 8'h00);

      // R3 sweep all rates, measure spacing of periodic flags
      for (int n = 1; n < 16; n++) begin
         int per, first, second, cyc;
         per = (n == 1) ? 128 : (n == 2) ? 256 : (1 << (n - 1));
         do_wr(2'd1, 8'(n));
         do_rd(2'd2, v);
         first = -1; second = -1; cyc = 0;
         while (second < 0 && cyc < 2 * per + 8) begin
            do_rd(2'd2, v);
            if (v[6]) begin
               if (first < 0) first = cyc; else second = cyc;
               if (n == 6) check("R4 periodic bit and low nibble", v, 8'h40);
            end
            cyc++;
         end
         check($sformatf("R3 rate %0d period", n), second - first, per);
      end
      ref_tick = 1'b0;
      do_wr(2'd1, 8'h00);
      do_rd(2'd2, v);

      // R4 flags latch with enables off; R5 summary stays low
      pulse(0); do_rd(2'd2, v); check("R4 alarm flag no enable", v, 8'h20);
      check("R5 irq low without enable", irq_o, 0);
      pulse(1); #1 check("R5 irq low update no enable", irq_o, 0);
      do_rd(2'd2, v); check("R4 update flag no enable", v, 8'h10);

      // R5 enabled alarm raises summary
      do_wr(2'd0, 8'h20);
      pulse(0); #1 check("R5 irq with alarm enabled", irq_o, 1);
      // R8 level hold
      repeat (5) @(negedge clk);
      check("R8 irq held", irq_o, 1);
      do_wr(2'd0, 8'h00); #1 check("R8 irq drops on disable", irq_o, 0);
      do_wr(2'd0, 8'h20); #1 check("R8 irq back on re-enable", irq_o, 1);
      // R6 read returns value then clears
      do_rd(2'd2, v); check("R6 read value", v, 8'hA0);
      #1 check("R6 irq cleared by read", irq_o, 0);
      do_rd(2'd2, v); check("R6 flags cleared", v, 8'h00);

      // R5 mismatched source: update flag with alarm enable only
      pulse(1); #1 check("R5 mismatched enable", irq_o, 0);
      do_rd(2'd2, v); check("R5 summary bit off", v, 8'h10);

      // R7 event coincident with clearing read
      do_wr(2'd0, 8'h30);
      pulse(1);
      rd_en = 1'b1; addr = 2'd2; alarm_evt = 1'b1;
      #1 v = rdata;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0; alarm_evt = 1'b0;
      check("R7 coincident read value", v, 8'h90);
      #1 check("R7 irq from kept alarm", irq_o, 1);
      do_rd(2'd2, v); check("R7 kept alarm flag", v, 8'hA0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end
endmodule